// File: doc/BRIEF.md
# Event-Triggered Delay Counter Channel

This block is one output channel of a timing receiver. Each cycle it may be offered a decoded 32-bit event frame. It compares that frame against a programmed trigger, which can be an exact match, a match in which masked bits are ignored, or an exact match that also needs the current telegram value to equal a reference. An accepted start loads a 22-bit delay counter. The start can come from a trigger match, from the previous channel's output, or from an external input. The counter then steps down on ticks from the base clock, the previous channel's output, a divided base clock or an external clock. When it expires, the channel drives a pulse of programmable width and polarity, a one-cycle interrupt request, or both.

Three firing modes are available. Single-shot mode fires one pulse and then disarms until the enable input is dropped. Counted mode fires N pulses, reloading the delay between them. Gated mode keeps firing while an external gate is high. A start that arrives while the counter is running is dropped and sets a sticky overrun flag. The external and chain inputs are assumed to be synchronous to `clk`. Frame decoding and clock generation are handled elsewhere.

Top module: `evt_delay_channel`

## Requirements
- R1: With `trig_kind`=0, a cycle with `frame_valid` high starts the channel only when `frame_data` equals `trig_pattern` in every bit.
- R2: With `trig_kind`=1, bits set in `trig_mask` are ignored: the channel starts when ((frame_data ^ trig_pattern) & ~trig_mask) is zero.
- R3: With `trig_kind`=2, the channel starts only when `frame_data` equals `trig_pattern` and `telegram_value` equals `tgm_ref`. `trig_kind`=3 never matches.
- R4: With `clk_sel`=0 (base clock), a start sampled at clock edge k with delay D gives `pulse_out` at its active level from edge k+D+1 for `pulse_width` cycles. A width of 0 is treated as 1, and D=0 fires on the first tick after the start.
- R5: `start_sel` picks the start source: 0 is a trigger match, 1 is a rising edge of `prev_out`, 2 is a rising edge of `ext_start`, and 3 is none. Sources that are not selected have no effect.
- R6: `clk_sel` picks the count tick: 0 is every cycle, 1 is a rising edge of `prev_out`, 2 is one cycle in every `harm_div`+1 with the phase restarted by each start, and 3 is a rising edge of `ext_clk`. The channel fires in the cycle of tick D+1 after the start, and the pulse shows at the next edge.
- R7: `fire_mode`=0 (single-shot, also used for code 3) fires once and then ignores starts until `enable` has been low for at least one cycle.
- R8: `fire_mode`=1 fires `pulse_count` pulses (0 is treated as 1). Each pulse follows the previous one by D+1 ticks, and the channel then disarms as in R7.
- R9: `fire_mode`=2 reloads and fires on each expiry while `burst_gate` is high. If the gate is low at an expiry, that expiry gives no pulse and the channel returns to idle, ready for a new start.
- R10: `act_out` enables the pulse and `act_irq` enables `irq`. `irq` is high for one cycle, aligned with the first active cycle of the pulse.
- R11: `pulse_out` equals `out_invert` while inactive and its complement while active.
- R12: A start that arrives while the counter is running is ignored and sets `overrun`, which stays high until reset.
- R13: After reset, `irq` and `overrun` are 0 and `pulse_out` equals `out_invert`.
- R14: While `enable` is low, all starts are ignored and a running count is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable; low aborts and re-arms |
| frame_valid | input | 1 | A decoded frame is present this cycle |
| frame_data | input | 32 | Decoded frame word |
| telegram_value | input | 16 | Current telegram value for qualified triggers |
| trig_kind | input | 2 | 0 exact, 1 masked, 2 telegram-qualified, 3 off |
| trig_pattern | input | 32 | Frame value to match |
| trig_mask | input | 32 | Bits ignored in masked mode |
| tgm_ref | input | 16 | Telegram value required in qualified mode |
| start_sel | input | 2 | Start source select |
| clk_sel | input | 2 | Count tick source select |
| harm_div | input | 8 | Divider setting for the divided tick |
| fire_mode | input | 2 | 0 single-shot, 1 counted, 2 gated |
| pulse_count | input | 8 | Pulses in counted mode |
| delay | input | 22 | Delay in ticks |
| pulse_width | input | 8 | Output pulse width in cycles |
| act_out | input | 1 | Enable the pulse action |
| act_irq | input | 1 | Enable the interrupt action |
| out_invert | input | 1 | Output polarity |
| ext_start | input | 1 | External start |
| ext_clk | input | 1 | External count clock |
| prev_out | input | 1 | Previous channel output, active high |
| burst_gate | input | 1 | Gate for gated mode |
| pulse_out | output | 1 | Channel pulse output |
| irq | output | 1 | Interrupt request pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check on every cycle that an interrupt appears only while a count is running and only when interrupts are enabled, that the counter starts only while enabled, that overrun rises only on a start that arrives while busy and then stays set, and that the block leaves reset quiet. Only the bench scenarios can show exact delay timing, the pulse counts of each firing mode, the mask and telegram matching, the choice of start and tick sources, the gate stopping a burst, and the output polarity.

// File: rtl/evt_chan_pkg.sv
// Package: shared encodings for the event-triggered delay channel.
// Assumes: all select fields are two bits wide.
package evt_chan_pkg;
    typedef enum logic [1:0] {
        TRIG_EXACT = 2'd0,
        TRIG_MASK  = 2'd1,
        TRIG_TGM   = 2'd2,
        TRIG_OFF   = 2'd3
    } trig_kind_e;

    typedef enum logic [1:0] {
        START_EVT   = 2'd0,
        START_CHAIN = 2'd1,
        START_EXT   = 2'd2,
        START_NONE  = 2'd3
    } start_sel_e;

    typedef enum logic [1:0] {
        TICK_BASE  = 2'd0,
        TICK_CHAIN = 2'd1,
        TICK_DIV   = 2'd2,
        TICK_EXT   = 2'd3
    } tick_sel_e;

    typedef enum logic [1:0] {
        FIRE_ONCE  = 2'd0,
        FIRE_MULTI = 2'd1,
        FIRE_BURST = 2'd2,
        FIRE_RSVD  = 2'd3
    } fire_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } core_st_e;
endpackage

// File: rtl/evt_chan_match.sv
// Module: evt_chan_match
// Compares one frame against the programmed trigger. Purely combinational.
// Assumes: frame_valid qualifies frame_data in the same cycle.
module evt_chan_match
    import evt_chan_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int TGM_W   = 16
) (
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic [TGM_W-1:0]   telegram_value,
    input  trig_kind_e         kind,
    input  logic [FRAME_W-1:0] pattern,
    input  logic [FRAME_W-1:0] mask,
    input  logic [TGM_W-1:0]   tgm_ref,
    output logic               hit
);
    logic [FRAME_W-1:0] diff;

    // Select the comparison rule that matches the trigger kind.
    always_comb begin
        diff = frame_data ^ pattern;
        unique case (kind)
            TRIG_EXACT: hit = frame_valid && (diff == '0);
            TRIG_MASK:  hit = frame_valid && ((diff & ~mask) == '0);
            TRIG_TGM:   hit = frame_valid && (diff == '0) && (telegram_value == tgm_ref);
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_chan_src.sv
// Module: evt_chan_src
// Picks the start source and the count tick source. It detects rising edges on
// the chain and external inputs and holds a divider whose phase restarts on load.
// Assumes: prev_in, ext_start and ext_clk are synchronous to clk.
module evt_chan_src
    import evt_chan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             prev_in,
    input  logic             ext_start,
    input  logic             ext_clk,
    input  start_sel_e       start_sel,
    input  tick_sel_e        tick_sel,
    input  logic [DIV_W-1:0] harm_div,
    input  logic             load,
    output logic             start,
    output logic             tick
);
    localparam int N_EDGE = 3;

    logic [N_EDGE-1:0] raw;
    logic [N_EDGE-1:0] rise;
    logic [DIV_W-1:0]  div_cnt;
    logic              div_tick;

    assign raw = {ext_clk, ext_start, prev_in};

    for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
        logic q;
        // Keep last cycle's level for rising-edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= raw[i];
        end
        assign rise[i] = raw[i] & ~q;
    end

    // Divide the base clock, restarting phase whenever the counter is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)                      div_cnt <= '0;
        else if (load)                   div_cnt <= '0;
        else if (div_cnt == harm_div)    div_cnt <= '0;
        else                             div_cnt <= div_cnt + 1'b1;
    end
    assign div_tick = (div_cnt == harm_div);

    // Route the selected start and tick sources.
    always_comb begin
        unique case (start_sel)
            START_EVT:   start = hit;
            START_CHAIN: start = rise[0];
            START_EXT:   start = rise[1];
            default:     start = 1'b0;
        endcase
        unique case (tick_sel)
            TICK_BASE:  tick = 1'b1;
            TICK_CHAIN: tick = rise[0];
            TICK_DIV:   tick = div_tick;
            default:    tick = rise[2];
        endcase
    end
endmodule

// File: rtl/evt_chan_core.sv
// Module: evt_chan_core
// The delay counter and its firing-mode state machine. It loads on an accepted
// start, counts down on ticks, fires on the tick that finds zero, and reloads
// or disarms according to the mode. It also flags starts that arrive while busy.
// Assumes: start and tick are single-cycle qualifiers in the clk domain.
module evt_chan_core
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 22,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] delay,
    input  fire_mode_e       mode,
    input  logic [NUM_W-1:0] n_pulses,
    input  logic             gate,
    output logic             load,
    output logic             fire,
    output logic             busy,
    output logic             overrun
);
    core_st_e         state;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] remain;
    logic             expire;

    assign busy   = (state == ST_COUNT);
    assign load   = enable && (state == ST_IDLE) && start;
    assign expire = enable && busy && tick && (cnt == '0);
    assign fire   = expire && ((mode != FIRE_BURST) || gate);

    // Advance the counter and the arm/count/done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            remain <= '0;
        end else if (!enable) begin
            state  <= ST_IDLE;
        end else if (load) begin
            state  <= ST_COUNT;
            cnt    <= delay;
            remain <= (n_pulses == '0) ? '0 : n_pulses - 1'b1;
        end else if (expire) begin
            unique case (mode)
                FIRE_MULTI: begin
                    if (remain == '0) begin
                        state <= ST_DONE;
                    end else begin
                        remain <= remain - 1'b1;
                        cnt    <= delay;
                    end
                end
                FIRE_BURST: begin
                    if (gate) cnt   <= delay;
                    else      state <= ST_IDLE;
                end
                default: state <= ST_DONE;
            endcase
        end else if (busy && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Latch a start that collides with a running count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (enable && busy && start)  overrun <= 1'b1;
    end
endmodule

// File: rtl/evt_chan_act.sv
// Module: evt_chan_act
// Turns a fire strobe into the configured actions: a pulse of programmable
// width and polarity, and a one-cycle interrupt request.
// Assumes: a fire during a running pulse restarts the width.
module evt_chan_act #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            act_out,
    input  logic            act_irq,
    input  logic            invert,
    input  logic [PW_W-1:0] width,
    output logic            pulse_out,
    output logic            irq
);
    logic [PW_W-1:0] pw_cnt;

    // Count down the remaining active cycles of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                pw_cnt <= '0;
        else if (fire && act_out)  pw_cnt <= (width == '0) ? PW_W'(1) : width;
        else if (pw_cnt != '0)     pw_cnt <= pw_cnt - 1'b1;
    end

    // Raise the interrupt request for one cycle on each enabled fire.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire && act_irq;
    end

    assign pulse_out = (pw_cnt != '0) ^ invert;
endmodule

// File: rtl/evt_delay_channel.sv
// Module: evt_delay_channel (top)
// One event-triggered delay channel: trigger match, source selection, delay
// counter with firing modes, and output actions.
// Assumes: every input is synchronous to clk; configuration is held stable
// while the channel is enabled.
module evt_delay_channel
    import evt_chan_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int TGM_W   = 16,
    parameter int CNT_W   = 22,
    parameter int NUM_W   = 8,
    parameter int PW_W    = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic [TGM_W-1:0]   telegram_value,
    input  logic [1:0]         trig_kind,
    input  logic [FRAME_W-1:0] trig_pattern,
    input  logic [FRAME_W-1:0] trig_mask,
    input  logic [TGM_W-1:0]   tgm_ref,
    input  logic [1:0]         start_sel,
    input  logic [1:0]         clk_sel,
    input  logic [DIV_W-1:0]   harm_div,
    input  logic [1:0]         fire_mode,
    input  logic [NUM_W-1:0]   pulse_count,
    input  logic [CNT_W-1:0]   delay,
    input  logic [PW_W-1:0]    pulse_width,
    input  logic               act_out,
    input  logic               act_irq,
    input  logic               out_invert,
    input  logic               ext_start,
    input  logic               ext_clk,
    input  logic               prev_out,
    input  logic               burst_gate,
    output logic               pulse_out,
    output logic               irq,
    output logic               overrun
);
    logic hit;
    logic start_evt;
    logic tick;
    logic load;
    logic fire;
    logic busy;

    evt_chan_match #(.FRAME_W(FRAME_W), .TGM_W(TGM_W)) u_match (
        .frame_valid    (frame_valid),
        .frame_data     (frame_data),
        .telegram_value (telegram_value),
        .kind           (trig_kind_e'(trig_kind)),
        .pattern        (trig_pattern),
        .mask           (trig_mask),
        .tgm_ref        (tgm_ref),
        .hit            (hit)
    );

    evt_chan_src #(.DIV_W(DIV_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .prev_in   (prev_out),
        .ext_start (ext_start),
        .ext_clk   (ext_clk),
        .start_sel (start_sel_e'(start_sel)),
        .tick_sel  (tick_sel_e'(clk_sel)),
        .harm_div  (harm_div),
        .load      (load),
        .start     (start_evt),
        .tick      (tick)
    );

    evt_chan_core #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start_evt),
        .tick     (tick),
        .delay    (delay),
        .mode     (fire_mode_e'(fire_mode)),
        .n_pulses (pulse_count),
        .gate     (burst_gate),
        .load     (load),
        .fire     (fire),
        .busy     (busy),
        .overrun  (overrun)
    );

    evt_chan_act #(.PW_W(PW_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .act_out   (act_out),
        .act_irq   (act_irq),
        .invert    (out_invert),
        .width     (pulse_width),
        .pulse_out (pulse_out),
        .irq       (irq)
    );
endmodule

// File: rtl/evt_delay_channel_chk.sv
// Module: evt_delay_channel_chk
// Protocol checks for evt_delay_channel, attached by bind.
// Assumes: busy and start_evt are the top's internal count and start strobes.
module evt_delay_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic act_irq,
    input logic irq,
    input logic overrun,
    input logic busy,
    input logic start_evt
);
    // R4: an interrupt only follows a cycle in which a count was running.
    p_irq_from_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(busy));

    // R10: an interrupt only when interrupt action was enabled.
    p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(act_irq));

    // R12: overrun rises only on a start seen while busy.
    p_overrun_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(busy) && $past(start_evt)));

    // R12: overrun is sticky.
    p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R13: quiet right after reset release.
    p_reset_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !overrun));

    // R14: counting only begins while enabled.
    p_start_enabled_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enable));
endmodule

bind evt_delay_channel evt_delay_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .act_irq   (act_irq),
    .irq       (irq),
    .overrun   (overrun),
    .busy      (busy),
    .start_evt (start_evt)
);

// File: tb/evt_delay_channel_bench.sv
// Directed bench for evt_delay_channel: one task per scenario.
module evt_delay_channel_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable;
    logic        frame_valid;
    logic [31:0] frame_data;
    logic [15:0] telegram_value;
    logic [1:0]  trig_kind;
    logic [31:0] trig_pattern;
    logic [31:0] trig_mask;
    logic [15:0] tgm_ref;
    logic [1:0]  start_sel;
    logic [1:0]  clk_sel;
    logic [7:0]  harm_div;
    logic [1:0]  fire_mode;
    logic [7:0]  pulse_count;
    logic [21:0] delay;
    logic [7:0]  pulse_width;
    logic        act_out;
    logic        act_irq;
    logic        out_invert;
    logic        ext_start;
    logic        ext_clk;
    logic        prev_out;
    logic        burst_gate;
    logic        pulse_out;
    logic        irq;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_delay_channel u_evt_delay_channel (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic defaults();
        enable = 1'b1; frame_valid = 1'b0; frame_data = '0; telegram_value = '0;
        trig_kind = 2'd0; trig_pattern = 32'h1234_5678; trig_mask = '0; tgm_ref = '0;
        start_sel = 2'd0; clk_sel = 2'd0; harm_div = 8'd0; fire_mode = 2'd0;
        pulse_count = 8'd1; delay = 22'd3; pulse_width = 8'd1; act_out = 1'b1;
        act_irq = 1'b0; out_invert = 1'b0; ext_start = 1'b0; ext_clk = 1'b0;
        prev_out = 1'b0; burst_gate = 1'b0;
    endtask

    // Present one frame for one cycle; returns at the negedge after its sampling edge.
    task automatic send_frame(input logic [31:0] d);
        @(negedge clk); frame_data = d; frame_valid = 1'b1;
        @(negedge clk); frame_valid = 1'b0;
    endtask

    task automatic kick_prev();
        @(negedge clk); prev_out = 1'b1;
        @(negedge clk); prev_out = 1'b0;
    endtask

    task automatic kick_ext();
        @(negedge clk); ext_start = 1'b1;
        @(negedge clk); ext_start = 1'b0;
    endtask

    task automatic ext_tick();
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); ext_clk = 1'b0;
    endtask

    // Sample n negedges; report first active index, active count, irq first and count.
    task automatic watch(input int n, output int first, output int nhi,
                         output int ifirst, output int nirq);
        first = -1; nhi = 0; ifirst = -1; nirq = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (pulse_out !== out_invert) begin
                nhi++;
                if (first < 0) first = j;
            end
            if (irq === 1'b1) begin
                nirq++;
                if (ifirst < 0) ifirst = j;
            end
        end
    endtask

    task automatic quiesce();
        @(negedge clk); enable = 1'b0;
        repeat (4) @(negedge clk);
        defaults();
    endtask

    task automatic t_reset();
        check(pulse_out === 1'b0, "R13 pulse_out idle", int'(pulse_out), 0);
        check(irq === 1'b0, "R13 irq", int'(irq), 0);
        check(overrun === 1'b0, "R13 overrun", int'(overrun), 0);
        out_invert = 1'b1; #1;
        check(pulse_out === 1'b1, "R13 R11 inverted idle", int'(pulse_out), 1);
        out_invert = 1'b0;
    endtask

    task automatic t_exact();
        int f, n, fi, ni;
        delay = 22'd3; pulse_width = 8'd2;
        send_frame(32'h1234_5679); watch(10, f, n, fi, ni);
        check(n == 0, "R1 near-miss ignored", n, 0);
        send_frame(32'h1234_5678); watch(10, f, n, fi, ni);
        check(f == 4, "R4 delay 3 timing", f, 4);
        check(n == 2, "R4 width 2", n, 2);
        quiesce();
    endtask

    task automatic t_zero();
        int f, n, fi, ni;
        delay = 22'd0; pulse_width = 8'd0;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(f == 1, "R4 delay 0 first tick", f, 1);
        check(n == 1, "R4 width 0 as 1", n, 1);
        quiesce();
    endtask

    task automatic t_wild();
        int f, n, fi, ni;
        trig_kind = 2'd1; trig_mask = 32'h0000_00FF; delay = 22'd1;
        send_frame(32'h1334_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R2 unmasked bit differs", n, 0);
        send_frame(32'h1234_56AB); watch(6, f, n, fi, ni);
        check(f == 2, "R2 masked bits ignored", f, 2);
        quiesce();
    endtask

    task automatic t_tgm();
        int f, n, fi, ni;
        trig_kind = 2'd2; tgm_ref = 16'h00A5; delay = 22'd1;
        telegram_value = 16'h00A4;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R3 telegram mismatch", n, 0);
        telegram_value = 16'h00A5;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(f == 2, "R3 telegram match", f, 2);
        trig_kind = 2'd3; quiesce(); trig_kind = 2'd3;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R3 kind 3 off", n, 0);
        quiesce();
    endtask

    task automatic t_start_src();
        int f, n, fi, ni;
        start_sel = 2'd1; delay = 22'd2;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R5 frame ignored on chain source", n, 0);
        kick_prev(); watch(6, f, n, fi, ni);
        check(f == 3, "R5 chain start", f, 3);
        quiesce();
        start_sel = 2'd2; delay = 22'd2;
        kick_prev(); watch(6, f, n, fi, ni);
        check(n == 0, "R5 chain ignored on external source", n, 0);
        kick_ext(); watch(6, f, n, fi, ni);
        check(f == 3, "R5 external start", f, 3);
        quiesce();
    endtask

    task automatic t_clk_src();
        int f, n, fi, ni;
        clk_sel = 2'd3; delay = 22'd2;
        send_frame(32'h1234_5678);
        ext_tick(); ext_tick();
        check(pulse_out === 1'b0, "R6 external clock 2 ticks", int'(pulse_out), 0);
        ext_tick();
        check(pulse_out === 1'b1, "R6 external clock 3rd tick", int'(pulse_out), 1);
        quiesce();
        clk_sel = 2'd2; harm_div = 8'd3; delay = 22'd1;
        send_frame(32'h1234_5678); watch(12, f, n, fi, ni);
        check(f == 8, "R6 divided tick", f, 8);
        quiesce();
        clk_sel = 2'd1; delay = 22'd0;
        send_frame(32'h1234_5678); watch(4, f, n, fi, ni);
        check(n == 0, "R6 chain clock waits", n, 0);
        @(negedge clk); prev_out = 1'b1;
        @(negedge clk); prev_out = 1'b0;
        check(pulse_out === 1'b1, "R6 chain clock tick", int'(pulse_out), 1);
        quiesce();
    endtask

    task automatic t_once();
        int f, n, fi, ni;
        delay = 22'd1;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 1, "R7 single pulse", n, 1);
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R7 disarmed", n, 0);
        check(overrun === 1'b0, "R7 R12 no overrun when done", int'(overrun), 0);
        quiesce(); delay = 22'd1;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(f == 2, "R7 re-armed by enable", f, 2);
        quiesce();
    endtask

    task automatic t_multi();
        int f, n, fi, ni;
        fire_mode = 2'd1; pulse_count = 8'd3; delay = 22'd2;
        send_frame(32'h1234_5678); watch(16, f, n, fi, ni);
        check(f == 3, "R8 first of series", f, 3);
        check(n == 3, "R8 pulse count", n, 3);
        quiesce();
        fire_mode = 2'd1; pulse_count = 8'd0; delay = 22'd1;
        send_frame(32'h1234_5678); watch(10, f, n, fi, ni);
        check(n == 1, "R8 count 0 as 1", n, 1);
        quiesce();
    endtask

    task automatic t_burst();
        int f, n, fi, ni;
        fire_mode = 2'd2; delay = 22'd1; burst_gate = 1'b1;
        send_frame(32'h1234_5678); watch(7, f, n, fi, ni);
        check(f == 2, "R9 burst first", f, 2);
        check(n == 3, "R9 burst repeats", n, 3);
        burst_gate = 1'b0;
        watch(10, f, n, fi, ni);
        check(n == 0, "R9 gate low stops", n, 0);
        burst_gate = 1'b1;
        send_frame(32'h1234_5678); watch(3, f, n, fi, ni);
        check(f == 2, "R9 idle after gate drop", f, 2);
        quiesce();
    endtask

    task automatic t_actions();
        int f, n, fi, ni;
        act_out = 1'b0; act_irq = 1'b1; delay = 22'd2;
        send_frame(32'h1234_5678); watch(8, f, n, fi, ni);
        check(n == 0, "R10 pulse disabled", n, 0);
        check(fi == 3, "R10 irq timing", fi, 3);
        check(ni == 1, "R10 irq one cycle", ni, 1);
        quiesce();
        out_invert = 1'b1; delay = 22'd1; pulse_width = 8'd3;
        @(negedge clk);
        check(pulse_out === 1'b1, "R11 inverted idle", int'(pulse_out), 1);
        send_frame(32'h1234_5678); watch(2, f, n, fi, ni);
        check(pulse_out === 1'b0, "R11 inverted active level", int'(pulse_out), 0);
        watch(6, f, n, fi, ni);
        check(n == 2, "R11 inverted width", n + 1, 3);
        quiesce();
    endtask

    task automatic t_enable();
        int f, n, fi, ni;
        delay = 22'd1;
        @(negedge clk); enable = 1'b0;
        send_frame(32'h1234_5678); watch(6, f, n, fi, ni);
        check(n == 0, "R14 disabled ignores start", n, 0);
        enable = 1'b1; delay = 22'd5;
        send_frame(32'h1234_5678); watch(2, f, n, fi, ni);
        enable = 1'b0; watch(8, f, n, fi, ni);
        check(n == 0, "R14 disable aborts count", n, 0);
        quiesce();
    endtask

    task automatic t_overrun();
        int f, n, fi, ni;
        delay = 22'd8;
        send_frame(32'h1234_5678); watch(2, f, n, fi, ni);
        check(overrun === 1'b0, "R12 no overrun yet", int'(overrun), 0);
        send_frame(32'h1234_5678);
        check(overrun === 1'b1, "R12 overrun set", int'(overrun), 1);
        watch(20, f, n, fi, ni);
        check(n == 1, "R12 second start ignored", n, 1);
        quiesce();
        check(overrun === 1'b1, "R12 overrun sticky", int'(overrun), 1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_zero();
        t_wild();
        t_tgm();
        t_start_src();
        t_clk_src();
        t_once();
        t_multi();
        t_burst();
        t_actions();
        t_enable();
        t_overrun();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule